// File: doc/BRIEF.md
# DDR PHY DLL Lock Controller

This block brings up the delay-locked loop of a memory PHY after reset. It writes the PHY control word in three separate steps. The first step loads the coarse start point and the increment step. The second step turns the loop on. The third step sets the start bit. The block then polls the PHY flags until all three lock indicators are high.

When lock arrives, the block copies the upper eight bits of the PHY's lock value into a force-delay field of the control word. It then tells the memory controller that bring-up is complete. For low-frequency operation, a mode input makes the block switch the PHY to the captured fixed delay by dropping the loop-enable bit.

A programmable timeout turns a lock that never arrives into an error flag, so the memory controller is not left waiting forever.

Top module: `dll_lock_ctrl`

## Requirements
- R1: In the first cycle after reset is released, `phyCtrl` takes the start point in bits [23:16] and the increment in bits [15:8]. Bits [31:24], [7:2], bit 1 (loop enable) and bit 0 (start) are all zero.
- R2: Loop enable (bit 1) is set one cycle after the load, and start (bit 0) is set one cycle after that. Start never rises while loop enable is low.
- R3: Lock is declared only when `phyFlags` equals 3'b111. Any other flag pattern leaves the block polling with `locked` low.
- R4: On lock, bits [31:24] of `phyCtrl` take `phyLockHi` (lock value bits [9:2]) as sampled in that cycle. Start point, increment, loop enable and start are kept.
- R5: With `lowFreqMode` high at lock, loop enable is cleared one cycle after capture. The force field, start point, increment and start bit are kept. With `lowFreqMode` low, loop enable stays set.
- R6: `done` is high for exactly one cycle. That cycle is the one right after capture in normal mode, and the one after the loop-enable clear in fixed-delay mode. `locked` stays high until reset.
- R7: The poll window spans `timeoutLimit`+1 cycles from the first poll. If the flags are not 3'b111 in any of those cycles, `timeoutErr` rises and stays high, and `done` and `locked` never rise. A lock seen in the last cycle of the window wins over the timeout.
- R8: While `rstN` is low at a clock edge, `phyCtrl`, `done`, `locked` and `timeoutErr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| lowFreqMode | input | 1 | Selects the fixed-delay fallback after lock |
| cfgStartPt | input | 8 | Coarse start point for the loop |
| cfgIncr | input | 8 | Increment step for the loop |
| timeoutLimit | input | TMO_W | Last poll cycle index before timeout |
| phyFlags | input | 3 | PHY lock indicator flags |
| phyLockHi | input | 8 | PHY lock value bits [9:2] |
| phyCtrl | output | 32 | PHY control word |
| done | output | 1 | One-cycle completion pulse |
| locked | output | 1 | Lock achieved, held until reset |
| timeoutErr | output | 1 | Lock never arrived within the window |

## Verification
The lock detection and the timeout expiry can both fall in the final poll cycle of the window. The bench provokes this by raising all three flags exactly at poll index `timeoutLimit`. It then expects `locked` high, `timeoutErr` low and one `done` pulse. The bench also raises the flags one cycle later, where the timeout must win. Random delays, partial flag patterns and random lock values cover the cases between these two.

// File: rtl/dll_lock_pkg.sv
package dll_lock_pkg;
  localparam int FIELD_W = 8;
  localparam int FLAG_W  = 3;
  localparam int RSVD_W  = 6;

  typedef struct packed {
    logic [FIELD_W-1:0] forceVal;
    logic [FIELD_W-1:0] startPt;
    logic [FIELD_W-1:0] incr;
    logic [RSVD_W-1:0]  rsvd;
    logic               dllOn;
    logic               dllStart;
  } phy_ctrl_t;

  typedef struct packed {
    logic loadCfg;
    logic setOn;
    logic setStart;
    logic capture;
    logic clearOn;
    logic incTimer;
    logic flagErr;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ENABLE, ST_START, ST_POLL, ST_FIX, ST_DONE, ST_HOLD, ST_FAIL
  } state_t;
endpackage

// File: rtl/dll_lock_ctrl_fsm.sv
module dll_lock_ctrl_fsm
  import dll_lock_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    lowFreqMode,
  input  logic    lockSeen,
  input  logic    timerAtLimit,
  output strobe_t stb,
  output logic    done
);
  state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE:   begin stb.loadCfg  = 1'b1; nextState = ST_ENABLE; end
      ST_ENABLE: begin stb.setOn    = 1'b1; nextState = ST_START;  end
      ST_START:  begin stb.setStart = 1'b1; nextState = ST_POLL;   end
      ST_POLL: begin
        // a lock in the last window cycle beats the timeout
        if (lockSeen) begin
          stb.capture = 1'b1;
          nextState   = lowFreqMode ? ST_FIX : ST_DONE;
        end else if (timerAtLimit) begin
          stb.flagErr = 1'b1;
          nextState   = ST_FAIL;
        end else begin
          stb.incTimer = 1'b1;
        end
      end
      ST_FIX:  begin stb.clearOn = 1'b1; nextState = ST_DONE; end
      ST_DONE: nextState = ST_HOLD;
      default: nextState = state;
    endcase
  end

  assign done = (state == ST_DONE);
endmodule

// File: rtl/dll_lock_ctrl_dp.sv
module dll_lock_ctrl_dp
  import dll_lock_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [FIELD_W-1:0] cfgStartPt,
  input  logic [FIELD_W-1:0] cfgIncr,
  input  logic [TMO_W-1:0]   timeoutLimit,
  input  logic [FLAG_W-1:0]  phyFlags,
  input  logic [FIELD_W-1:0] phyLockHi,
  output phy_ctrl_t          ctrlQ,
  output logic               lockSeen,
  output logic               timerAtLimit,
  output logic               lockedQ,
  output logic               errQ
);
  logic [TMO_W-1:0] pollTimer;

  assign lockSeen     = &phyFlags;
  assign timerAtLimit = (pollTimer == timeoutLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ     <= '0;
      pollTimer <= '0;
      lockedQ   <= 1'b0;
      errQ      <= 1'b0;
    end else begin
      if (stb.loadCfg) begin
        ctrlQ.forceVal <= '0;
        ctrlQ.startPt  <= cfgStartPt;
        ctrlQ.incr     <= cfgIncr;
        ctrlQ.rsvd     <= '0;
        ctrlQ.dllOn    <= 1'b0;
        ctrlQ.dllStart <= 1'b0;
        pollTimer      <= '0;
      end
      if (stb.setOn)    ctrlQ.dllOn    <= 1'b1;
      if (stb.setStart) ctrlQ.dllStart <= 1'b1;
      if (stb.capture) begin
        ctrlQ.forceVal <= phyLockHi;
        lockedQ        <= 1'b1;
      end
      if (stb.clearOn)  ctrlQ.dllOn <= 1'b0;
      if (stb.incTimer) pollTimer   <= pollTimer + 1'b1;
      if (stb.flagErr)  errQ        <= 1'b1;
    end
  end
endmodule

// File: rtl/dll_lock_ctrl.sv
module dll_lock_ctrl
  import dll_lock_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lowFreqMode,
  input  logic [FIELD_W-1:0] cfgStartPt,
  input  logic [FIELD_W-1:0] cfgIncr,
  input  logic [TMO_W-1:0]   timeoutLimit,
  input  logic [FLAG_W-1:0]  phyFlags,
  input  logic [FIELD_W-1:0] phyLockHi,
  output logic [31:0]        phyCtrl,
  output logic               done,
  output logic               locked,
  output logic               timeoutErr
);
  strobe_t   stb;
  phy_ctrl_t ctrlQ;
  logic      lockSeen, timerAtLimit;

  dll_lock_ctrl_fsm u_fsm (
    .clk(clk), .rstN(rstN), .lowFreqMode(lowFreqMode), .lockSeen(lockSeen),
    .timerAtLimit(timerAtLimit), .stb(stb), .done(done)
  );

  dll_lock_ctrl_dp #(.TMO_W(TMO_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgStartPt(cfgStartPt), .cfgIncr(cfgIncr),
    .timeoutLimit(timeoutLimit), .phyFlags(phyFlags), .phyLockHi(phyLockHi),
    .ctrlQ(ctrlQ), .lockSeen(lockSeen), .timerAtLimit(timerAtLimit),
    .lockedQ(locked), .errQ(timeoutErr)
  );

  assign phyCtrl = ctrlQ;
endmodule

// File: rtl/dll_lock_ctrl_chk.sv
module dll_lock_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  phyFlags,
  input logic [7:0]  phyLockHi,
  input logic [31:0] phyCtrl,
  input logic        done,
  input logic        locked,
  input logic        timeoutErr
);
  assert_start_after_on_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phyCtrl[0]) |-> $past(phyCtrl[1]));

  assert_lock_needs_flags_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(phyFlags) == 3'b111);

  assert_force_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> phyCtrl[31:24] == $past(phyLockHi));

  assert_on_drop_after_lock_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phyCtrl[1]) |-> locked);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_locked_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);

  assert_err_excludes_lock_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(timeoutErr && locked));
endmodule

bind dll_lock_ctrl dll_lock_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .phyFlags(phyFlags), .phyLockHi(phyLockHi),
  .phyCtrl(phyCtrl), .done(done), .locked(locked), .timeoutErr(timeoutErr)
);

// File: tb/test_dll_lock_ctrl.sv
`timescale 1ns/1ps
module test_dll_lock_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lowFreqMode = 1'b0;
  logic [7:0]  cfgStartPt = '0, cfgIncr = '0;
  logic [15:0] timeoutLimit = '0;
  logic [2:0]  phyFlags = '0;
  logic [7:0]  phyLockHi = '0;
  logic [31:0] phyCtrl;
  logic        done, locked, timeoutErr;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  dll_lock_ctrl #(.TMO_W(16)) i_dll_lock_ctrl (
    .clk(clk), .rstN(rstN), .lowFreqMode(lowFreqMode), .cfgStartPt(cfgStartPt),
    .cfgIncr(cfgIncr), .timeoutLimit(timeoutLimit), .phyFlags(phyFlags),
    .phyLockHi(phyLockHi), .phyCtrl(phyCtrl), .done(done), .locked(locked),
    .timeoutErr(timeoutErr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expCtrl(input logic [7:0] f, input logic [7:0] sp,
                                          input logic [7:0] inc, input bit on, input bit st);
    return {f, sp, inc, 6'b0, on, st};
  endfunction

  task automatic runOne(input int d, input bit fix, input int limit);
    logic [7:0] sp, inc, forceExp;
    bit lockOk;
    int total, doneCnt, doneAt, expDoneAt;
    sp = 8'($urandom); inc = 8'($urandom);
    lockOk = (d <= limit);
    forceExp = '0; doneCnt = 0; doneAt = -1;
    @(negedge clk);
    rstN = 1'b0; cfgStartPt = sp; cfgIncr = inc; lowFreqMode = fix;
    timeoutLimit = 16'(limit); phyFlags = '0; phyLockHi = 8'($urandom);
    repeat (3) @(negedge clk);
    chk(phyCtrl == 0 && !done && !locked && !timeoutErr, "R8 reset",
        {phyCtrl[31:3], done, locked, timeoutErr}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(phyCtrl == expCtrl(8'h0, sp, inc, 0, 0), "R1 load", phyCtrl, expCtrl(8'h0, sp, inc, 0, 0));
    @(negedge clk);
    chk(phyCtrl == expCtrl(8'h0, sp, inc, 1, 0), "R2 on", phyCtrl, expCtrl(8'h0, sp, inc, 1, 0));
    @(negedge clk);
    chk(phyCtrl == expCtrl(8'h0, sp, inc, 1, 1), "R2 start", phyCtrl, expCtrl(8'h0, sp, inc, 1, 1));
    total = ((d < limit) ? limit : d) + 6;
    for (int p = 0; p < total; p++) begin
      if (done) begin
        doneCnt++;
        doneAt = p;
        if (fix) chk(phyCtrl[1] == 1'b0, "R5 on cleared at done", {31'b0, phyCtrl[1]}, 32'h0);
      end
      if (p == d && lockOk)
        chk(!locked, "R3 partial flags ignored", {31'b0, locked}, 32'h0);
      phyLockHi = 8'($urandom);
      if (p >= d) phyFlags = 3'b111;
      else        phyFlags = 3'($urandom_range(0, 6));
      if (p == d) forceExp = phyLockHi;
      if (p < total - 1) @(negedge clk);
    end
    if (lockOk) begin
      chk(phyCtrl == expCtrl(forceExp, sp, inc, !fix, 1), fix ? "R5 fixed word" : "R4 locked word",
          phyCtrl, expCtrl(forceExp, sp, inc, !fix, 1));
      expDoneAt = d + (fix ? 2 : 1);
      chk(doneAt == expDoneAt, "R6 done timing", 32'(doneAt), 32'(expDoneAt));
    end else begin
      chk(phyCtrl == expCtrl(8'h0, sp, inc, 1, 1), "R7 word after timeout",
          phyCtrl, expCtrl(8'h0, sp, inc, 1, 1));
    end
    chk(doneCnt == (lockOk ? 1 : 0), "R6 done count", 32'(doneCnt), 32'(lockOk ? 1 : 0));
    chk(locked == lockOk && timeoutErr == !lockOk, "R7 outcome",
        {30'b0, locked, timeoutErr}, {30'b0, lockOk, !lockOk});
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    runOne(0, 0, 5);     // immediate lock
    runOne(7, 0, 7);     // lock and timeout in the same cycle: lock wins (R7)
    runOne(8, 0, 7);     // one cycle late: timeout
    runOne(3, 1, 10);    // fixed-delay fallback
    runOne(0, 1, 0);     // zero window, fixed mode
    runOne(1, 0, 0);     // zero window, timeout
    for (int i = 0; i < 20; i++) begin
      int lim, dly;
      lim = $urandom_range(0, 40);
      dly = $urandom_range(0, 45);
      runOne(dly, 1'($urandom), lim);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule